// File: doc/BRIEF.md
# Paired-Channel Deadtime Driver

This block produces six gate-drive outputs for a six-step brushless motor drive. The outputs are organised as three channel pairs, bit 0 with bit 1, bit 2 with bit 3 and bit 4 with bit 5. In every pair the even bit is the lower index. Each channel has an active flag and a PWM-enable flag, both supplied by the phase sequencer. One PWM source is shared by all pairs, and a programmable deadtime sets how long a rising output edge is held back.

When complementary mode is on, each pair has its own deadtime unit. The active channel of the pair chooses what that unit does: it carries the PWM and its partner carries the inverted PWM. Every rise of either output is delayed by the deadtime, measured in clock cycles. If both channels of a pair are active, both outputs are forced low so that the high and low devices never conduct together. A pair with neither channel active stays fully low, which leaves the phase floating for back-EMF sensing. When complementary mode is off, each output simply follows its own channel with no deadtime.

The configuration is held in a small register loaded through a write strobe. The deadtime resets to all ones and complementary mode resets to on. Complementary mode cannot be switched off while the paired-mode control input is high. All pins are plain level signals sampled on the clock; there is no streaming data path and so no handshake.

Top module: `pair_deadtime_drv`

## Requirements
- R1: A synchronous active-high reset drives every output to 0, loads the deadtime with all ones (255 for the default 8-bit width) and turns complementary mode on.
- R2: With complementary mode on and exactly one channel of a pair active with PWM enabled, the active output follows the PWM source and the partner follows its inverse. This holds whether the active channel is the even or the odd one.
- R3: A pair with neither channel active drives both outputs to 0 one clock after the inputs are sampled, whatever the PWM source does.
- R4: With complementary mode on and both channels of a pair active, both outputs of that pair are 0 one clock later.
- R5: With complementary mode on, an active channel whose PWM is disabled drives a steady 1 once the deadtime has elapsed, and its partner drives 0.
- R6: Outputs are registered. If a pair's requested output pattern changes at sampling edge k, a falling output goes low at edge k, and a rising output goes high at edge k+D, where D is the programmed deadtime.
- R7: A request that stays high for D sampling edges or fewer never reaches the output. A request that stays high for L > D edges produces an output that is high for L-D cycles.
- R8: While complementary mode is on, the two outputs of a pair are never 1 in the same cycle.
- R9: With complementary mode off, each output equals, one clock later, its active flag ANDed with (the PWM source if its PWM flag is set, else 1). There is no deadtime in this mode, and both channels of a pair may be high together.
- R10: When the write strobe is high, the deadtime and mode are loaded for the following cycles. The exception is a write that would turn complementary mode off while it is on and the paired-mode input is high: that write is ignored entirely, and neither the mode nor the deadtime changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; deadtime is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| pwm_src | input | 1 | Shared PWM source |
| ch_on | input | 2*PAIRS | Per-channel active flag; bit 2p is the even channel of pair p |
| ch_pwm | input | 2*PAIRS | Per-channel PWM enable |
| pair_mode | input | 1 | Paired-mode control; while high, complementary mode cannot be cleared |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dt | input | DT_W | Deadtime value to load, in clock cycles |
| cfg_comp | input | 1 | Complementary-mode value to load |
| drv_out | output | 2*PAIRS | Gated drive outputs |

## Verification
The properties assume that every input is synchronous to the clock and is read only at the rising edge. They also assume that the mode bit used at one edge is the one whose effect appears on the outputs at the next edge. The bench therefore changes inputs one time unit after a rising edge and samples the outputs at the same point, so every value is stable across the edge that consumes it. Configuration writes are issued only while all channels are inactive, or while the pattern on the outputs is already settled. This keeps a mode change from being checked against an output that was computed under the previous mode.

// File: rtl/pair_deadtime_pkg.sv
package pair_deadtime_pkg;
  localparam int unsigned PAIRS_DEF = 3;
  localparam int unsigned DT_W_DEF  = 8;

  typedef struct packed {
    logic hi_o;
    logic hi_e;
  } pair_req_t;
endpackage

// File: rtl/pdg_cfg_reg.sv
module pdg_cfg_reg #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pair_mode,
  input  logic            wr_en,
  input  logic [DT_W-1:0] wr_dt,
  input  logic            wr_comp,
  output logic [DT_W-1:0] dt_q,
  output logic            comp_q
);
  logic wr_blocked;

  // clearing complementary mode is refused while the paired-mode input is high
  assign wr_blocked = comp_q && !wr_comp && pair_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      dt_q   <= '1;
      comp_q <= 1'b1;
    end else if (wr_en && !wr_blocked) begin
      dt_q   <= wr_dt;
      comp_q <= wr_comp;
    end
  end
endmodule

// File: rtl/pdg_pair_steer.sv
module pdg_pair_steer
  import pair_deadtime_pkg::*;
(
  input  logic      on_e,
  input  logic      on_o,
  input  logic      pen_e,
  input  logic      pen_o,
  input  logic      pwm,
  input  logic      comp,
  output pair_req_t req
);
  logic lvl_e, lvl_o;

  assign lvl_e = pen_e ? pwm : 1'b1;
  assign lvl_o = pen_o ? pwm : 1'b1;

  always_comb begin
    req = '0;
    if (!comp) begin
      req.hi_e = on_e & lvl_e;
      req.hi_o = on_o & lvl_o;
    end else if (on_e && !on_o) begin
      req.hi_e = lvl_e;
      req.hi_o = pen_e & ~pwm;
    end else if (on_o && !on_e) begin
      req.hi_o = lvl_o;
      req.hi_e = pen_o & ~pwm;
    end
    // both active or both idle under complementary mode: both low
  end
endmodule

// File: rtl/pdg_dt_unit.sv
module pdg_dt_unit
  import pair_deadtime_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  pair_req_t       req,
  input  logic [DT_W-1:0] dt,
  output logic            out_e,
  output logic            out_o
);
  localparam logic [DT_W-1:0] AGE_MAX = '1;

  pair_req_t       req_q;
  logic [DT_W-1:0] age_q, age_d;
  logic            ripe;

  // age counts the sampling edges since the requested pattern last changed
  always_comb begin
    if (req != req_q)
      age_d = '0;
    else if (age_q == AGE_MAX)
      age_d = age_q;
    else
      age_d = age_q + 1'b1;
  end

  assign ripe = (age_d >= dt);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      age_q <= '0;
      out_e <= 1'b0;
      out_o <= 1'b0;
    end else begin
      req_q <= req;
      age_q <= age_d;
      out_e <= req.hi_e & ripe;
      out_o <= req.hi_o & ripe;
    end
  end
endmodule

// File: rtl/pair_deadtime_drv.sv
module pair_deadtime_drv
  import pair_deadtime_pkg::*;
#(
  parameter int unsigned PAIRS = PAIRS_DEF,
  parameter int unsigned DT_W  = DT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwm_src,
  input  logic [2*PAIRS-1:0] ch_on,
  input  logic [2*PAIRS-1:0] ch_pwm,
  input  logic               pair_mode,
  input  logic               cfg_we,
  input  logic [DT_W-1:0]    cfg_dt,
  input  logic               cfg_comp,
  output logic [2*PAIRS-1:0] drv_out
);
  localparam int unsigned NCH = 2 * PAIRS;

  logic [DT_W-1:0] dt_q, dt_eff;
  logic            comp_q;

  pdg_cfg_reg #(.DT_W(DT_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .pair_mode (pair_mode),
    .wr_en     (cfg_we),
    .wr_dt     (cfg_dt),
    .wr_comp   (cfg_comp),
    .dt_q      (dt_q),
    .comp_q    (comp_q)
  );

  // no deadtime is inserted when the channels run independently
  assign dt_eff = comp_q ? dt_q : '0;

  logic [NCH-1:0] out_w;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    pair_req_t req;

    pdg_pair_steer u_steer (
      .on_e  (ch_on[2*p]),
      .on_o  (ch_on[2*p+1]),
      .pen_e (ch_pwm[2*p]),
      .pen_o (ch_pwm[2*p+1]),
      .pwm   (pwm_src),
      .comp  (comp_q),
      .req   (req)
    );

    pdg_dt_unit #(.DT_W(DT_W)) u_dt (
      .clk   (clk),
      .rst   (rst),
      .req   (req),
      .dt    (dt_eff),
      .out_e (out_w[2*p]),
      .out_o (out_w[2*p+1])
    );
  end

  assign drv_out = out_w;
endmodule

// File: rtl/pair_deadtime_drv_chk.sv
module pair_deadtime_drv_chk #(
  parameter int unsigned PAIRS = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               pwm_src,
  input logic [2*PAIRS-1:0] ch_on,
  input logic [2*PAIRS-1:0] ch_pwm,
  input logic               pair_mode,
  input logic               cfg_we,
  input logic               cfg_comp,
  input logic               comp_on,
  input logic [2*PAIRS-1:0] drv_out
);
  for (genvar p = 0; p < PAIRS; p++) begin : g_p
    p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
      (!ch_on[2*p] && !ch_on[2*p+1]) |=> (drv_out[2*p+1 -: 2] == 2'b00));

    p_lockout_r4: assert property (@(posedge clk) disable iff (rst)
      (comp_on && ch_on[2*p] && ch_on[2*p+1]) |=> (drv_out[2*p+1 -: 2] == 2'b00));

    p_partner_off_e_r5: assert property (@(posedge clk) disable iff (rst)
      (comp_on && ch_on[2*p] && !ch_on[2*p+1] && !ch_pwm[2*p]) |=> !drv_out[2*p+1]);

    p_partner_off_o_r5: assert property (@(posedge clk) disable iff (rst)
      (comp_on && ch_on[2*p+1] && !ch_on[2*p] && !ch_pwm[2*p+1]) |=> !drv_out[2*p]);

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
      $past(comp_on) |-> !(drv_out[2*p] && drv_out[2*p+1]));

    p_bypass_e_r9: assert property (@(posedge clk) disable iff (rst)
      !comp_on |=> (drv_out[2*p] == $past(ch_on[2*p] && (!ch_pwm[2*p] || pwm_src))));

    p_bypass_o_r9: assert property (@(posedge clk) disable iff (rst)
      !comp_on |=> (drv_out[2*p+1] == $past(ch_on[2*p+1] && (!ch_pwm[2*p+1] || pwm_src))));
  end

  p_cfg_lock_r10: assert property (@(posedge clk) disable iff (rst)
    (comp_on && pair_mode && cfg_we && !cfg_comp) |=> comp_on);
endmodule

bind pair_deadtime_drv pair_deadtime_drv_chk #(.PAIRS(PAIRS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwm_src   (pwm_src),
  .ch_on     (ch_on),
  .ch_pwm    (ch_pwm),
  .pair_mode (pair_mode),
  .cfg_we    (cfg_we),
  .cfg_comp  (cfg_comp),
  .comp_on   (comp_q),
  .drv_out   (drv_out)
);

// File: tb/pair_deadtime_drv_tb.sv
module pair_deadtime_drv_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_src = 1'b0;
  logic [5:0] ch_on = '0;
  logic [5:0] ch_pwm = '0;
  logic       pair_mode = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_dt = '0;
  logic       cfg_comp = 1'b0;
  logic [5:0] drv_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pair_deadtime_drv #(.PAIRS(3), .DT_W(8)) u_dut (
    .clk(clk), .rst(rst), .pwm_src(pwm_src), .ch_on(ch_on), .ch_pwm(ch_pwm),
    .pair_mode(pair_mode), .cfg_we(cfg_we), .cfg_dt(cfg_dt), .cfg_comp(cfg_comp),
    .drv_out(drv_out)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] dt, input logic comp);
    cfg_dt = dt; cfg_comp = comp; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    tick(3);
    chk("R1 outputs low in reset", drv_out, 6'b000000);
    rst = 1'b0;
    ch_on = 6'b000001; ch_pwm = 6'b000000;
    tick(255);
    chk("R1 reset deadtime 255 holds rise", drv_out, 6'b000000);
    tick(1);
    chk("R5 steady 1 after reset deadtime", drv_out, 6'b000001);
  endtask

  task automatic t_steer;
    ch_on = '0; tick(2);
    wr_cfg(8'd3, 1'b1);
    ch_on = 6'b001001; ch_pwm = 6'b001001; pwm_src = 1'b1;
    tick(3);
    chk("R6 rise held for deadtime", drv_out, 6'b000000);
    tick(1);
    chk("R2 even and odd active carry pwm", drv_out, 6'b001001);
    pwm_src = 1'b0;
    tick(1);
    chk("R6 fall at once", drv_out, 6'b000000);
    tick(2);
    chk("R6 partner rise held", drv_out, 6'b000000);
    tick(1);
    chk("R2 partners carry inverted pwm", drv_out, 6'b000110);
    pwm_src = 1'b1;
    tick(1);
    chk("R6 partner fall at once", drv_out, 6'b000000);
    tick(3);
    chk("R2 back to active side", drv_out, 6'b001001);
  endtask

  task automatic t_overlap;
    for (int i = 0; i < 40; i++) begin
      pwm_src = 1'($urandom_range(1, 0));
      tick(1);
      chk("R8 no pair high together",
          {3'b000, drv_out[5] & drv_out[4], drv_out[3] & drv_out[2], drv_out[1] & drv_out[0]},
          6'b000000);
    end
  endtask

  task automatic t_short_pulse;
    pwm_src = 1'b1; tick(5);
    chk("R7 settled before pulse", drv_out, 6'b001001);
    pwm_src = 1'b0; tick(1);
    chk("R7 short low pulse k", drv_out, 6'b000000);
    tick(1);
    chk("R7 short pulse suppressed", drv_out, 6'b000000);
    pwm_src = 1'b1; tick(1);
    chk("R7 active rise restarts", drv_out, 6'b000000);
    tick(2);
    chk("R7 active still held", drv_out, 6'b000000);
    tick(1);
    chk("R7 active after deadtime", drv_out, 6'b001001);
    pwm_src = 1'b0; tick(3);
    chk("R7 pulse of D+1 before rise", drv_out, 6'b000000);
    tick(1);
    chk("R7 pulse of D+1 gives one cycle", drv_out, 6'b000110);
    pwm_src = 1'b1; tick(1);
    chk("R7 one-cycle pulse ends", drv_out, 6'b000000);
  endtask

  task automatic t_idle;
    ch_on = '0; ch_pwm = 6'b111111;
    for (int i = 0; i < 8; i++) begin
      pwm_src = ~pwm_src;
      tick(1);
      chk("R3 idle pairs low", drv_out, 6'b000000);
    end
  endtask

  task automatic t_both;
    ch_on = 6'b000111; ch_pwm = 6'b000111; pwm_src = 1'b1;
    tick(4);
    chk("R4 both active pair off, other pair runs", drv_out, 6'b000100);
    pwm_src = 1'b0;
    tick(4);
    chk("R4 both active pair stays off", drv_out, 6'b001000);
  endtask

  task automatic t_bypass;
    ch_on = '0; tick(1);
    wr_cfg(8'd3, 1'b0);
    ch_on = 6'b110011; ch_pwm = 6'b010001; pwm_src = 1'b1;
    tick(1);
    chk("R9 independent channels pwm high", drv_out, 6'b110011);
    pwm_src = 1'b0;
    tick(1);
    chk("R9 independent channels pwm low", drv_out, 6'b100010);
  endtask

  task automatic t_cfg_lock;
    ch_on = '0; pair_mode = 1'b1;
    wr_cfg(8'd2, 1'b1);
    wr_cfg(8'd5, 1'b0);
    ch_on = 6'b000001; ch_pwm = 6'b000001; pwm_src = 1'b1;
    tick(2);
    chk("R10 deadtime 2 kept", drv_out, 6'b000000);
    tick(1);
    chk("R10 rise after 2", drv_out, 6'b000001);
    pwm_src = 1'b0;
    tick(2);
    chk("R10 mode still complementary, held", drv_out, 6'b000000);
    tick(1);
    chk("R10 mode still complementary", drv_out, 6'b000010);
    ch_on = '0; pair_mode = 1'b0;
    wr_cfg(8'd5, 1'b0);
    ch_on = 6'b000001; pwm_src = 1'b0;
    tick(1);
    chk("R10 clear accepted, pwm low", drv_out, 6'b000000);
    pwm_src = 1'b1;
    tick(1);
    chk("R10 clear accepted, no deadtime", drv_out, 6'b000001);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got cycle %0d expected under %0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_steer();
    t_overlap();
    t_short_pulse();
    t_idle();
    t_both();
    t_bypass();
    t_cfg_lock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule